// File: doc/BRIEF.md
# Supply Low-Voltage Warning Control and Status Register

This block is a single byte-wide control and status register that turns a set of supply-monitor comparator outputs into a software-visible warning. Four synchronous "supply below threshold" indications arrive, one per selectable trip level. A two-bit select field picks the one that is watched. A drop of the watched indication latches a sticky warning flag. Software clears the flag by writing 1 to an acknowledge bit. An enable bit turns the flag into a level interrupt request.

Two synchronous active-low resets act on the block. The power-on reset clears everything. The general reset clears the flag and the enable but keeps the level select. On leaving either reset, the block re-evaluates the watched indication. A supply that is already low therefore raises the warning at once. A change of the level select counts as a new comparison in the same way. The register sits at byte offset 1 of a small address window, and read data is combinational from the register state.

Top module: `lvw_status_reg`

## Requirements
- R1: A read at offset 1 returns {flag (bit 7), 0 (bit 6), interrupt enable (bit 5), 000 (bits 4..2), level select (bits 1..0)}, and a read at any other offset returns 0x00.
- R2: The flag becomes 1 on the clock edge where the watched indication is 1 after having been 0 on the previous edge with the same select.
- R3: On the first clock edge after either reset is released, the flag becomes 1 if the watched indication is already 1.
- R4: A write at offset 1 with bit 6 = 1 clears the flag. A write with bit 6 = 0 leaves the flag unchanged, and bit 6 always reads 0.
- R5: Write data in bits 4..2 is ignored, and those bits read 0.
- R6: irq_o is 1 exactly when both the flag and the interrupt enable are 1.
- R7: Level select code k (00, 01, 10, 11) makes below_i[k] the watched indication, and the other indications have no effect.
- R8: While por_n is low at a clock edge, the register becomes 0x00, including the level select.
- R9: While rst_n is low and por_n is high at a clock edge, bits 7..2 become 0 and the level select keeps its value.
- R10: When a set condition and an acknowledge write meet on the same edge, the flag is 1 afterwards.
- R11: After the level select is written to a new code, the flag becomes 1 on the following edge if the newly watched indication is 1.
- R12: Once set, the flag stays 1 when the indication returns to 0, until an acknowledge or a reset.
- R13: A write at an offset other than 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | General reset, synchronous, active low |
| below_i | input | 4 | Supply-below-threshold indications, one per trip level, already synchronous |
| addr_i | input | 4 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets the moments where the edge detector could see a stale or wrong comparison. These are the first edge after each reset type, a select change onto a level that is already low, and an acknowledge that meets a fresh set. A design that reloaded the edge history wrongly would miss the warning after reset, or raise it twice. A design that gave the acknowledge priority would lose a warning. The bench also checks that the general reset keeps the select while the power-on reset clears it. It checks that unwatched levels, reserved bits, a 0 in the acknowledge bit and writes at other offsets leave every bit unchanged.

// File: rtl/lvw_pkg.sv
// Package: field positions of the low-voltage warning register.
// Assumes an 8-bit register; bit positions are fixed because software decodes them.
package lvw_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = 7;
    localparam int ACK_BIT  = 6;
    localparam int IEN_BIT  = 5;
    localparam int RSV_HI   = 4;
    localparam int RSV_LO   = 2;
endpackage

// File: rtl/lvw_level_sel.sv
// lvw_level_sel: picks the watched below-threshold indication and detects a new
// "below" condition. A new condition is the indication being 1 when either it
// was 0 on the last edge or the select changed since the last edge.
// Assumes below_i is already synchronous to clk; the history is reloaded to
// "not below" on every reset so a low supply is seen again on reset release.
module lvw_level_sel #(
    parameter int NUM_LEVELS = 4,
    localparam int SEL_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] below_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic                  set_o
);
    logic             watched;
    logic             prev_below_q;
    logic [SEL_W-1:0] prev_sel_q;

    // Select the indication addressed by the level code.
    always_comb watched = below_i[sel_i];

    // A set is requested when the watched level is low and this is a new comparison.
    always_comb set_o = watched && (!prev_below_q || (prev_sel_q != sel_i));

    // Keep last edge's watched value and select; cleared history on any reset.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            prev_below_q <= 1'b0;
            prev_sel_q   <= sel_i;
        end else begin
            prev_below_q <= watched;
            prev_sel_q   <= sel_i;
        end
    end
endmodule

// File: rtl/lvw_ctrl_regs.sv
// lvw_ctrl_regs: address decode and the software-written fields (interrupt
// enable and level select), plus the acknowledge strobe.
// Assumes single-cycle writes; the level select survives the general reset.
module lvw_ctrl_regs #(
    parameter int ADDR_W     = 4,
    parameter int REG_OFFSET = 1,
    parameter int SEL_W      = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              wr_ack_i,
    input  logic              wr_ien_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    output logic              hit_o,
    output logic              ack_o,
    output logic              ien_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic             ien_q;
    logic [SEL_W-1:0] sel_q;

    // Decode the register offset.
    always_comb hit_o = (addr_i == ADDR_W'(REG_OFFSET));

    // Acknowledge strobe: a write of 1 into the acknowledge bit.
    always_comb ack_o = wr_en_i && hit_o && wr_ack_i;

    // Interrupt enable: cleared by both resets.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) ien_q <= 1'b0;
        else if (wr_en_i && hit_o) ien_q <= wr_ien_i;
    end

    // Level select: cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) sel_q <= '0;
        else if (rst_n && wr_en_i && hit_o) sel_q <= wr_sel_i;
    end

    assign ien_o = ien_q;
    assign sel_o = sel_q;

    // R9: general reset keeps the level select.
    a_r9_sel_kept: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> sel_q == $past(sel_q));

    // R8: power-on reset clears enable and select.
    a_r8_por_clear: assert property (@(posedge clk)
        !por_n |=> (sel_q == '0) && !ien_q);
endmodule

// File: rtl/lvw_flag.sv
// lvw_flag: sticky warning flag. Set has priority over acknowledge; both
// resets clear it.
// Assumes set_i and ack_i are single-cycle conditions from the same clock.
module lvw_flag (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_o
);
    logic flag_q;

    // Flag update: reset, then set, then acknowledge.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) flag_q <= 1'b0;
        else if (set_i)       flag_q <= 1'b1;
        else if (ack_i)       flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R2, R10: a set condition always leaves the flag at 1.
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        set_i |=> flag_q);

    // R4: an acknowledge without a set clears the flag.
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (ack_i && !set_i) |=> !flag_q);

    // R12: the flag holds without an acknowledge.
    a_r12_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (flag_q && !ack_i) |=> flag_q);

    // R2: the flag only rises after a set condition.
    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(flag_q) |-> $past(set_i));
endmodule

// File: rtl/lvw_status_reg.sv
// lvw_status_reg: low-voltage warning control/status register. Ties the level
// selector, the control fields and the sticky flag together and builds the
// read data and the interrupt request.
// Assumes NUM_LEVELS = 2**SEL_W and SEL_W <= 2 so the select fits bits 1..0.
module lvw_status_reg
    import lvw_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    parameter int ADDR_W     = 4,
    parameter int REG_OFFSET = 1
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] below_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_en_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [REG_W-1:0]      rdata_o,
    output logic                  irq_o
);
    localparam int SEL_W = $clog2(NUM_LEVELS);

    logic             hit;
    logic             ack;
    logic             ien;
    logic [SEL_W-1:0] sel;
    logic             set_req;
    logic             flag;
    logic             unused_wdata;

    // Write-data bits with no storage behind them.
    assign unused_wdata = ^{wdata_i[FLAG_BIT], wdata_i[RSV_HI:RSV_LO]};

    lvw_ctrl_regs #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET),
        .SEL_W      (SEL_W)
    ) u_ctrl (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .wr_ack_i (wdata_i[ACK_BIT]),
        .wr_ien_i (wdata_i[IEN_BIT]),
        .wr_sel_i (wdata_i[SEL_W-1:0]),
        .hit_o    (hit),
        .ack_o    (ack),
        .ien_o    (ien),
        .sel_o    (sel)
    );

    lvw_level_sel #(
        .NUM_LEVELS (NUM_LEVELS)
    ) u_level (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .below_i (below_i),
        .sel_i   (sel),
        .set_o   (set_req)
    );

    lvw_flag u_flag (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .set_i  (set_req),
        .ack_i  (ack),
        .flag_o (flag)
    );

    // Read data: register image at its offset, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (hit) begin
            rdata_o[FLAG_BIT]  = flag;
            rdata_o[IEN_BIT]   = ien;
            rdata_o[SEL_W-1:0] = sel;
        end
    end

    // Interrupt request while flag and enable are both set.
    always_comb irq_o = flag && ien;
endmodule

// File: tb/lvw_status_reg_tb.sv
// Bench for lvw_status_reg: table-driven main walk, then directed reset tests.
module lvw_status_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic       clk = 1'b0;
    logic       por_n, rst_n;
    logic [3:0] below;
    logic [3:0] addr;
    logic       wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvw_status_reg u_dut (
        .clk     (clk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .below_i (below),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    // Entry: {req[3:0], below[3:0], wr, addr[3:0], wdata[7:0], exp_rdata[7:0], exp_irq}
    localparam logic [29:0] VEC [NV] = '{
        {4'd1,  4'b0000, 1'b1, 4'd1, 8'h22, 8'h22, 1'b0}, // R1 enable + select 2
        {4'd2,  4'b0100, 1'b0, 4'd1, 8'h00, 8'hA2, 1'b1}, // R2 watched level drops, R6 irq
        {4'd12, 4'b0000, 1'b0, 4'd1, 8'h00, 8'hA2, 1'b1}, // R12 sticky
        {4'd4,  4'b0000, 1'b1, 4'd1, 8'h62, 8'h22, 1'b0}, // R4 acknowledge
        {4'd5,  4'b0000, 1'b1, 4'd1, 8'h3E, 8'h22, 1'b0}, // R5 reserved ignored
        {4'd6,  4'b0100, 1'b1, 4'd1, 8'h02, 8'h82, 1'b0}, // R6 flag without enable
        {4'd4,  4'b0100, 1'b1, 4'd1, 8'h02, 8'h82, 1'b0}, // R4 bit6=0 no effect
        {4'd4,  4'b0100, 1'b1, 4'd1, 8'h42, 8'h02, 1'b0}, // R4 ack, bit6 reads 0
        {4'd13, 4'b0100, 1'b1, 4'd2, 8'hFF, 8'h02, 1'b0}, // R13 other offset write
        {4'd11, 4'b0101, 1'b1, 4'd1, 8'h20, 8'h20, 1'b0}, // R11 select write
        {4'd11, 4'b0101, 1'b0, 4'd1, 8'h00, 8'hA0, 1'b1}, // R11 new level already low
        {4'd4,  4'b0101, 1'b1, 4'd1, 8'h60, 8'h20, 1'b0}, // R4 ack with level steady
        {4'd7,  4'b1000, 1'b1, 4'd1, 8'h21, 8'h21, 1'b0}, // R7 select 1
        {4'd7,  4'b1000, 1'b0, 4'd1, 8'h00, 8'h21, 1'b0}, // R7 level 3 ignored
        {4'd7,  4'b1010, 1'b0, 4'd1, 8'h00, 8'hA1, 1'b1}, // R7 level 1 watched
        {4'd11, 4'b1010, 1'b1, 4'd1, 8'h63, 8'h23, 1'b0}, // R11 ack + select 3
        {4'd11, 4'b1010, 1'b0, 4'd1, 8'h00, 8'hA3, 1'b1}, // R11 level 3 already low
        {4'd4,  4'b0000, 1'b1, 4'd1, 8'h63, 8'h23, 1'b0}, // R4 clear
        {4'd10, 4'b1000, 1'b1, 4'd1, 8'h63, 8'hA3, 1'b1}  // R10 set beats ack
    };

    task automatic check(input string req, input logic [7:0] exp_rd, input logic exp_irq);
        checks++;
        if (rdata !== exp_rd || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                     req, rdata, irq, exp_rd, exp_irq);
        end
    endtask

    // One clock edge, then read back the register at its offset.
    task automatic edge_then_read();
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        addr  = 4'd1;
        #1;
    endtask

    initial begin
        por_n = 1'b0; rst_n = 1'b0; below = 4'b0000;
        addr = 4'd1; wr_en = 1'b0; wdata = 8'h00;
        repeat (3) @(posedge clk);
        #3;
        check("R8", 8'h00, 1'b0);
        por_n = 1'b1; rst_n = 1'b1;
        edge_then_read();
        check("R8", 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            below = VEC[i][25:22];
            wr_en = VEC[i][21];
            addr  = VEC[i][20:17];
            wdata = VEC[i][16:9];
            edge_then_read();
            check($sformatf("R%0d", VEC[i][29:26]), VEC[i][8:1], VEC[i][0]);
        end

        // R1: other offsets read zero while the register is non-zero.
        addr = 4'd2; #1;
        check("R1", 8'h00, 1'b1);
        addr = 4'd0; #1;
        check("R1", 8'h00, 1'b1);
        addr = 4'd1;

        // R9: general reset clears flag and enable, keeps select 3.
        rst_n = 1'b0;
        edge_then_read();
        check("R9", 8'h03, 1'b0);
        edge_then_read();
        check("R9", 8'h03, 1'b0);
        // R3: level 3 still low at release, flag returns.
        rst_n = 1'b1;
        edge_then_read();
        check("R3", 8'h83, 1'b0);
        edge_then_read();
        check("R3", 8'h83, 1'b0);

        // R8: power-on reset clears everything including select.
        por_n = 1'b0;
        edge_then_read();
        check("R8", 8'h00, 1'b0);
        // R3: after power-on reset, select 0 watches level 0, already low.
        below = 4'b0001;
        edge_then_read();
        check("R8", 8'h00, 1'b0);
        por_n = 1'b1;
        edge_then_read();
        check("R3", 8'h80, 1'b0);
        // R12: one flag only, level returns high, flag stays.
        below = 4'b0000;
        edge_then_read();
        check("R12", 8'h80, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule